// File: doc/BRIEF.md
# Carrier Oscillator and Quadrature Up-Mixer

This block moves a complex baseband stream onto a digital carrier. A phase accumulator, stepped by a 32-bit tuning word, points into a full-cycle sine table. Each clock the block multiplies the incoming in-phase sample by the cosine of the current phase and the quadrature sample by the sine. It subtracts the second product from the first and sends out one rounded, saturated real sample.

After reset the accumulator is parked at phase zero and no samples are produced. The tuning word can be loaded while parked, so the carrier starts cleanly. A sync event releases the accumulator from phase zero. The event comes from a host write to a command address or from an edge on an external pin, and the active pin edge is programmable. Every sync event is repeated on an output pin for one clock, so follower units can start on the same cycle and share carrier phase.

The host writes one byte per clock through a simple port. The tuning word goes in as four bytes. Writing the top byte commits the whole word.

Top module: `carrier_upmix`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `out_sample` is 0 and `out_valid` and `sync_out` are 0. Reset clears the tuning word to 0 and the sync polarity to 0.
- R2: From reset until the first sync event, the accumulator stays at phase 0, `out_valid` stays 0 and `out_sample` stays 0, whatever is written to the tuning word.
- R3: A write with `wr_en` high to addresses 0, 1 and 2 stores byte 0 (least significant), byte 1 and byte 2 of the tuning word in a holding register. These writes alone leave the oscillator's step unchanged.
- R4: After a sync event at clock edge s, the accumulator holds 0 until edge s+1. At each following edge it adds the tuning word, modulo 2^32.
- R5: The top 10 accumulator bits form an index k. The sine term is round(32767·sin(2πk/1024)) and the cosine term is round(32767·cos(2πk/1024)), with halves rounded away from zero.
- R6: The sample registered at an edge is sat16((I·cos − Q·sin + 2^14) >> 15), using the inputs and the phase present before that edge. `out_valid` is 1 for samples taken while the oscillator runs.
- R7: A write to address 5 with any data is a sync event in the clock of the write.
- R8: Bit 0 of a write to address 4 sets the pin polarity. With 0, a low-to-high change of `sync_in` between two clock samples is a sync event. With 1, a high-to-low change is. A change in the other direction has no effect.
- R9: `sync_out` is high for exactly the one clock after each sync event and low otherwise.
- R10: A sync event while the oscillator runs returns the phase to 0, and counting restarts as in R4.
- R11: A write to address 3 supplies byte 3 and commits all four bytes. If the oscillator runs, the old word is used at the commit edge and the new word from the next edge on.
- R12: Sums outside the 16-bit range are clamped to 32767 or −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write byte |
| sync_in | input | 1 | External sync pin, sampled on `clk` |
| i_in | input | 16 | In-phase sample, two's complement |
| q_in | input | 16 | Quadrature sample, two's complement |
| out_sample | output | 16 | Mixed carrier sample, two's complement |
| out_valid | output | 1 | Output sample comes from a running oscillator |
| sync_out | output | 1 | One-clock copy of each sync event for follower units |

## Verification
The assertions assume that `sync_in` is already synchronous to `clk`, so an edge is simply a change between two clock samples. They also assume `wr_addr` and `wr_data` matter only while `wr_en` is high. The bench changes every input just after the falling clock edge and holds `wr_en` for exactly one clock per write, which keeps within both assumptions. The table sweeps step the phase by exactly one table entry per clock, so every index is reached for the sine path, the cosine path and both saturation corners. Tuning-word changes and pin edges of both polarities are applied while the oscillator runs, so that phase continuity and phase restart can both be seen at the output.

// File: rtl/upmix_pkg.sv
package upmix_pkg;

  localparam int SAMPLE_W  = 16;
  localparam int WIDE_W    = 2 * SAMPLE_W + 1;
  localparam int AMPLITUDE = (1 << (SAMPLE_W - 1)) - 1;
  localparam real TWO_PI   = 6.283185307179586;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [WIDE_W-1:0]   wide_t;

  // One entry of the full-cycle sine table, rounded half away from zero.
  function automatic int wave_point(int k, int depth);
    real v;
    v = real'(AMPLITUDE) * $sin(TWO_PI * real'(k) / real'(depth));
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  // I*cos - Q*sin, scaled back by 2^(SAMPLE_W-1) with round-half-up,
  // then clamped to the sample range.
  function automatic sample_t mix_point(sample_t i_s, sample_t q_s,
                                        sample_t c_s, sample_t s_s);
    wide_t acc;
    wide_t lim_hi;
    wide_t lim_lo;
    lim_hi = wide_t'(AMPLITUDE);
    lim_lo = -lim_hi - wide_t'(1);
    acc = wide_t'(i_s) * wide_t'(c_s) - wide_t'(q_s) * wide_t'(s_s);
    acc = acc + (wide_t'(1) <<< (SAMPLE_W - 2));
    acc = acc >>> (SAMPLE_W - 1);
    if (acc > lim_hi) return sample_t'(lim_hi[SAMPLE_W-1:0]);
    if (acc < lim_lo) return sample_t'(lim_lo[SAMPLE_W-1:0]);
    return sample_t'(acc[SAMPLE_W-1:0]);
  endfunction

endpackage

// File: rtl/upmix_regs.sv
module upmix_regs #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  output logic [PHASE_W-1:0] freq_word,
  output logic               sync_pol,
  output logic               sw_sync,
  output logic               commit
);

  localparam int NBYTES    = PHASE_W / 8;
  localparam int TOP_ADDR  = NBYTES - 1;
  localparam int POL_ADDR  = NBYTES;
  localparam int SYNC_ADDR = NBYTES + 1;

  logic [PHASE_W-9:0] stage;

  assign commit  = wr_en && (wr_addr == ADDR_W'(TOP_ADDR));
  assign sw_sync = wr_en && (wr_addr == ADDR_W'(SYNC_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage     <= '0;
      freq_word <= '0;
      sync_pol  <= 1'b0;
    end else begin
      for (int b = 0; b < NBYTES - 1; b++) begin
        if (wr_en && (wr_addr == ADDR_W'(b))) stage[8*b +: 8] <= wr_data;
      end
      if (commit) freq_word <= {wr_data, stage};
      if (wr_en && (wr_addr == ADDR_W'(POL_ADDR))) sync_pol <= wr_data[0];
    end
  end

endmodule

// File: rtl/upmix_sync.sv
module upmix_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic sync_pol,
  input  logic sw_sync,
  output logic sync_evt,
  output logic sync_out
);

  logic pin_q;
  logic pin_edge;

  // Last sample of the pin, taken during reset as well so that a level
  // already present at release is not seen as an edge.
  always_ff @(posedge clk) pin_q <= sync_in;

  assign pin_edge = sync_pol ? (pin_q & ~sync_in) : (sync_in & ~pin_q);
  assign sync_evt = sw_sync | pin_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_out <= 1'b0;
    else        sync_out <= sync_evt;
  end

endmodule

// File: rtl/upmix_phase.sv
module upmix_phase #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_evt,
  input  logic [PHASE_W-1:0] freq_word,
  output logic [PHASE_W-1:0] phase,
  output logic               running
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      running <= 1'b0;
    end else if (sync_evt) begin
      phase   <= '0;
      running <= 1'b1;
    end else if (running) begin
      phase <= phase + freq_word;
    end
  end

endmodule

// File: rtl/upmix_mixer.sv
module upmix_mixer
  import upmix_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               running,
  input  logic [PHASE_W-1:0] phase,
  input  sample_t            i_in,
  input  sample_t            q_in,
  output sample_t            out_sample,
  output logic               out_valid
);

  localparam int DEPTH = 1 << LUT_AW;
  localparam int QTR   = DEPTH / 4;

  sample_t           wave [DEPTH];
  logic [LUT_AW-1:0] sin_idx;
  logic [LUT_AW-1:0] cos_idx;
  sample_t           sin_v;
  sample_t           cos_v;
  sample_t           mixed;

  for (genvar g = 0; g < DEPTH; g++) begin : g_wave
    assign wave[g] = sample_t'(wave_point(g, DEPTH));
  end

  assign sin_idx = phase[PHASE_W-1 -: LUT_AW];
  assign cos_idx = sin_idx + LUT_AW'(QTR);
  assign sin_v   = wave[sin_idx];
  assign cos_v   = wave[cos_idx];
  assign mixed   = mix_point(i_in, q_in, cos_v, sin_v);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_sample <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid  <= running;
      out_sample <= running ? mixed : '0;
    end
  end

endmodule

// File: rtl/carrier_upmix.sv
module carrier_upmix
  import upmix_pkg::*;
#(
  parameter  int PHASE_W = 32,
  parameter  int LUT_AW  = 10,
  localparam int ADDR_W  = $clog2(PHASE_W / 8 + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                sync_in,
  input  logic [SAMPLE_W-1:0] i_in,
  input  logic [SAMPLE_W-1:0] q_in,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic                out_valid,
  output logic                sync_out
);

  logic [PHASE_W-1:0] freq_word;
  logic [PHASE_W-1:0] phase;
  logic               sync_pol;
  logic               sw_sync;
  logic               commit;
  logic               sync_evt;
  logic               running;

  upmix_regs #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .freq_word(freq_word), .sync_pol(sync_pol),
    .sw_sync(sw_sync), .commit(commit)
  );

  upmix_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_pol(sync_pol),
    .sw_sync(sw_sync), .sync_evt(sync_evt), .sync_out(sync_out)
  );

  upmix_phase #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .sync_evt(sync_evt), .freq_word(freq_word),
    .phase(phase), .running(running)
  );

  upmix_mixer #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW)) u_mixer (
    .clk(clk), .rst_n(rst_n), .running(running), .phase(phase),
    .i_in(i_in), .q_in(q_in), .out_sample(out_sample), .out_valid(out_valid)
  );

endmodule

// File: rtl/carrier_upmix_chk.sv
module carrier_upmix_chk #(
  parameter int PHASE_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sync_evt,
  input logic               running,
  input logic [PHASE_W-1:0] phase,
  input logic [PHASE_W-1:0] freq_word,
  input logic               sync_out,
  input logic               out_valid,
  input logic [15:0]        out_sample,
  input logic               sync_in,
  input logic               sync_pol,
  input logic               commit,
  input logic [7:0]         wr_data
);

  AST_PARKED_UNTIL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !sync_evt) |=> (!running && $stable(phase))); // R2

  AST_QUIET_WHILE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (!out_valid && out_sample == '0)); // R2

  AST_SYNC_RESTARTS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> (running && phase == '0)); // R10

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !sync_evt) |=> (phase == $past(phase) + $past(freq_word))); // R4

  AST_SYNC_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> sync_out); // R9

  AST_SYNC_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_evt |=> !sync_out); // R9

  AST_RISING_PIN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_pol && $rose(sync_in)) |-> sync_evt); // R8

  AST_FALLING_PIN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pol && $fell(sync_in)) |-> sync_evt); // R8

  AST_COMMIT_TOP_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (freq_word[PHASE_W-1 -: 8] == $past(wr_data))); // R11

  AST_VALID_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> out_valid); // R6

endmodule

bind carrier_upmix carrier_upmix_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_evt(sync_evt), .running(running),
  .phase(phase), .freq_word(freq_word), .sync_out(sync_out),
  .out_valid(out_valid), .out_sample(out_sample), .sync_in(sync_in),
  .sync_pol(sync_pol), .commit(commit), .wr_data(wr_data)
);

// File: tb/carrier_upmix_test.sv
module carrier_upmix_test;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        sync_in;
  logic [15:0] i_in;
  logic [15:0] q_in;
  logic [15:0] out_sample;
  logic        out_valid;
  logic        sync_out;

  int          checks = 0;
  int          fails  = 0;
  logic [31:0] mp;   // phase the design should hold between edges
  logic [31:0] mf;   // step the design should be using

  always #10 clk = ~clk;

  carrier_upmix uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_in(sync_in), .i_in(i_in), .q_in(q_in),
    .out_sample(out_sample), .out_valid(out_valid), .sync_out(sync_out)
  );

  function automatic int ref_wave(int k, bit use_cos);
    real a;
    real v;
    a = 2.0 * 3.141592653589793 * real'(k) / real'(DEPTH);
    v = 32767.0 * (use_cos ? $cos(a) : $sin(a));
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  function automatic int ref_mix(int iv, int qv, logic [31:0] ph);
    int k;
    longint s;
    k = int'(ph[31:22]);
    s = longint'(iv) * longint'(ref_wave(k, 1'b1)) - longint'(qv) * longint'(ref_wave(k, 1'b0));
    s = s + 64'sd16384;
    s = s >>> 15;
    if (s > 64'sd32767) s = 64'sd32767;
    if (s < -64'sd32768) s = -64'sd32768;
    return int'(s);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic write_reg(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_freq(logic [31:0] f);
    for (int b = 0; b < 4; b++) write_reg(b, int'(f[8*b +: 8]));
    mf = f;
  endtask

  task automatic soft_sync();
    write_reg(5, 8'h5a);
    chk("R7", int'(sync_out), 1);
    mp = '0;
  endtask

  // pattern 0 keeps the present i_in/q_in, pattern 1 sweeps them per clock
  task automatic run(int cycles, int pattern, string tag);
    for (int n = 0; n < cycles; n++) begin
      if (pattern == 1) begin
        i_in = 16'(n * 2749 + 123);
        q_in = 16'(n * 40503 + 17);
      end
      @(negedge clk);
      chk(tag, int'($signed(out_sample)), ref_mix(int'($signed(i_in)), int'($signed(q_in)), mp));
      chk("R6", int'(out_valid), 1);
      chk("R9", int'(sync_out), 0);
      mp = mp + mf;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    sync_in = 1'b0; i_in = 16'sd20000; q_in = -16'sd12345;
    mp = '0; mf = '0;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1", int'(out_sample), 0);
    chk("R1", int'(out_valid), 0);
    chk("R1", int'(sync_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(out_valid), 0);

    // R2: parked while the tuning word is loaded
    set_freq(32'h0040_0000);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      chk("R2", int'(out_valid), 0);
      chk("R2", int'(out_sample), 0);
    end

    // R5: cosine sweep, then sine sweep, one table step per clock
    i_in = 16'sd32767; q_in = 16'sd0;
    soft_sync();
    run(1030, 0, "R5");
    i_in = 16'sd0; q_in = -16'sd32767;
    soft_sync();
    run(1024, 0, "R5");

    // R12: both saturation corners
    i_in = 16'sd32767; q_in = 16'sd32767;
    soft_sync();
    run(1024, 0, "R12");
    i_in = -16'sd32768; q_in = -16'sd32768;
    soft_sync();
    run(1024, 0, "R12");

    // R6 and R4: fractional steps with wrap, changing inputs
    set_freq(32'h0123_4567);
    soft_sync();
    run(300, 1, "R6");
    set_freq(32'hFEDC_BA99);
    i_in = 16'sd9000; q_in = -16'sd31000;
    soft_sync();
    run(200, 0, "R4");

    // R3 / R11: partial writes ignored, commit applies from the next edge
    for (int n = 0; n < 30; n++) begin
      wr_en = 1'b0;
      if (n == 3)  begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h00; end
      if (n == 4)  begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h00; end
      if (n == 5)  begin wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h80; end
      if (n == 15) begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h05; end
      @(negedge clk);
      chk((n < 15) ? "R3" : "R11", int'($signed(out_sample)),
          ref_mix(int'($signed(i_in)), int'($signed(q_in)), mp));
      mp = mp + mf;
      if (n == 15) mf = 32'h0580_0000;
    end
    wr_en = 1'b0;

    // R8 / R10: pin syncs of both polarities while running
    sync_in = 1'b1;
    @(negedge clk);
    chk("R8", int'(sync_out), 1);
    mp = '0;
    run(8, 0, "R10");
    sync_in = 1'b0;
    run(8, 0, "R8");
    write_reg(4, 1);
    mp = mp + mf;
    sync_in = 1'b1;
    run(6, 0, "R8");
    sync_in = 1'b0;
    @(negedge clk);
    chk("R8", int'(sync_out), 1);
    mp = '0;
    run(6, 0, "R8");
    write_reg(4, 0);
    mp = mp + mf;

    // R1: reset while running clears output and the tuning word
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", int'(out_sample), 0);
    chk("R1", int'(out_valid), 0);
    chk("R1", int'(sync_out), 0);
    rst_n = 1'b1;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      chk("R2", int'(out_valid), 0);
    end
    mf = '0;
    soft_sync();
    run(5, 1, "R1");

    report();
  end

endmodule